// File: doc/BRIEF.md
# Accumulator Machine Execute Unit

This block is the execute stage of a 40-bit single-accumulator processor. It holds the two architectural data registers: the accumulator and the multiplier-quotient register. The fetch stage hands it an 8-bit opcode and a 12-bit operand address X. The unit makes at most one read and at most one write through a request/acknowledge memory port. It then updates the accumulator or the multiplier-quotient register and reports completion with a one-cycle done pulse.

Branch opcodes do not touch memory. Instead they return a jump request to the fetch stage, made of a target address, a flag that selects the right or left half of the target word, and a taken flag. Two address-patch opcodes read a stored word and replace one of its 12-bit address fields with the low bits of the accumulator. They then write the word back.

All data values are two's complement and arithmetic wraps modulo 2^40. Multiply, divide and every opcode not listed below complete as no-ops.

Top module: `accm_exec`

## Requirements
- R1: After reset, ac_out and mq_out are zero, and busy, done, mem_req and jump_valid are low.
- R2: An instruction is accepted on a clock edge where issue_valid is high and busy is low. busy is high from the next cycle until completion. done is high for exactly one cycle, the cycle in which busy has fallen. issue_valid is ignored while busy is high. AC and MQ change only in a done cycle.
- R3: mem_req, mem_we, mem_addr and mem_wdata stay stable until mem_ack. Read-class opcodes make exactly one read at X, 0x21 makes exactly one write at X, 0x12 and 0x13 make one read and then one write at X, and all other opcodes make no memory access.
- R4: Opcodes 0x01, 0x02, 0x03 and 0x04 set AC to M(X), -M(X), |M(X)| and -|M(X)| respectively.
- R5: Opcode 0x09 sets MQ to M(X). Opcode 0x0A sets AC to MQ.
- R6: Opcode 0x21 writes AC to M(X) and leaves AC and MQ unchanged.
- R7: Opcodes 0x05, 0x07, 0x06 and 0x08 set AC to AC+M(X), AC+|M(X)|, AC-M(X) and AC-|M(X)|, modulo 2^40.
- R8: Opcode 0x14 shifts AC left by one bit, shifting in a zero. Opcode 0x15 shifts AC right by one bit, copying the sign bit (vector bit 39, the leftmost bit) into the vacated position.
- R9: Opcodes 0x0D to 0x10 raise jump_valid together with done, with jump_addr = X. jump_right is 1 for 0x0E and 0x10 and 0 for 0x0D and 0x0F. 0x0D and 0x0E are always taken. 0x0F and 0x10 are taken only when AC bit 39 is 0.
- R10: Opcode 0x12 writes back M(X) with vector bits [31:20] replaced by AC[11:0]. Opcode 0x13 writes back M(X) with bits [11:0] replaced by AC[11:0]. All other bits of the word are kept.
- R11: Any other opcode, including 0x0B and 0x0C, makes no memory access, leaves AC and MQ unchanged, pulses done, and does not raise jump_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered by the fetch stage |
| issue_op | input | 8 | Opcode |
| issue_addr | input | 12 | Operand address X |
| issue_ready | output | 1 | Unit is idle and will accept an instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 40 | Write data |
| mem_ack | input | 1 | Access complete; read data valid on this cycle |
| mem_rdata | input | 40 | Read data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| jump_valid | output | 1 | Branch result is valid |
| jump_taken | output | 1 | Branch is taken |
| jump_right | output | 1 | Target is the right half of the word |
| jump_addr | output | 12 | Branch target address |
| ac_out | output | 40 | Accumulator |
| mq_out | output | 40 | Multiplier-quotient register |

## Verification
The bench applies every one of the 256 opcodes against operand sets chosen to expose specific faults:
- **Sign and overflow edges.** The sets include the most negative value, minus one and zero. A wrong absolute value, or a negation that fails to wrap, therefore shows up directly in AC.
- **Right shift.** A negative accumulator makes a logical right shift visible.
- **Conditional branches.** Sign-bit flips exercise the taken decision.
- **Address-patch opcodes.** The patched word has all bits set around the field and the accumulator has distinct low bits. A misplaced or mis-sized field merge therefore corrupts visible neighbouring bits.
- **Memory traffic.** The memory model varies its acknowledge latency and counts reads and writes per instruction. It catches a missing access or an extra one, such as a store that also reads or a no-op that touches memory.
- **Handshake.** An instruction offered while busy must not execute.

// File: rtl/accm_pkg.sv
package accm_pkg;

   localparam int OP_W = 8;

   // opcode map (fixed encoding)
   localparam logic [OP_W-1:0] OPC_LD      = 8'h01;
   localparam logic [OP_W-1:0] OPC_LDNEG   = 8'h02;
   localparam logic [OP_W-1:0] OPC_LDABS   = 8'h03;
   localparam logic [OP_W-1:0] OPC_LDNABS  = 8'h04;
   localparam logic [OP_W-1:0] OPC_ADD     = 8'h05;
   localparam logic [OP_W-1:0] OPC_SUB     = 8'h06;
   localparam logic [OP_W-1:0] OPC_ADDABS  = 8'h07;
   localparam logic [OP_W-1:0] OPC_SUBABS  = 8'h08;
   localparam logic [OP_W-1:0] OPC_LDMQ    = 8'h09;
   localparam logic [OP_W-1:0] OPC_MQ2AC   = 8'h0A;
   localparam logic [OP_W-1:0] OPC_JMPL    = 8'h0D;
   localparam logic [OP_W-1:0] OPC_JMPR    = 8'h0E;
   localparam logic [OP_W-1:0] OPC_JGEL    = 8'h0F;
   localparam logic [OP_W-1:0] OPC_JGER    = 8'h10;
   localparam logic [OP_W-1:0] OPC_PATCHL  = 8'h12;
   localparam logic [OP_W-1:0] OPC_PATCHR  = 8'h13;
   localparam logic [OP_W-1:0] OPC_SHL     = 8'h14;
   localparam logic [OP_W-1:0] OPC_SHR     = 8'h15;
   localparam logic [OP_W-1:0] OPC_STORE   = 8'h21;

   typedef enum logic [3:0] {
      FN_KEEP,
      FN_LD,
      FN_LDNEG,
      FN_LDABS,
      FN_LDNABS,
      FN_ADD,
      FN_ADDABS,
      FN_SUB,
      FN_SUBABS,
      FN_SHL,
      FN_SHR,
      FN_FROM_MQ
   } alu_fn_e;

   typedef struct packed {
      logic    rd;
      logic    wr;
      logic    wr_ac;
      logic    wr_mq;
      logic    is_patch;
      logic    patch_right;
      logic    is_br;
      logic    br_cond;
      logic    br_right;
      alu_fn_e fn;
   } dec_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_FIN
   } exec_st_e;

endpackage

// File: rtl/accm_decode.sv
module accm_decode
   import accm_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output dec_t            dec
);

   always_comb begin
      dec = '0;
      dec.fn = FN_KEEP;
      unique case (op)
         OPC_LD:     begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_LD;     end
         OPC_LDNEG:  begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_LDNEG;  end
         OPC_LDABS:  begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_LDABS;  end
         OPC_LDNABS: begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_LDNABS; end
         OPC_ADD:    begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_ADD;    end
         OPC_ADDABS: begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_ADDABS; end
         OPC_SUB:    begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_SUB;    end
         OPC_SUBABS: begin dec.rd = 1'b1; dec.wr_ac = 1'b1; dec.fn = FN_SUBABS; end
         OPC_LDMQ:   begin dec.rd = 1'b1; dec.wr_mq = 1'b1; end
         OPC_MQ2AC:  begin dec.wr_ac = 1'b1; dec.fn = FN_FROM_MQ; end
         OPC_SHL:    begin dec.wr_ac = 1'b1; dec.fn = FN_SHL; end
         OPC_SHR:    begin dec.wr_ac = 1'b1; dec.fn = FN_SHR; end
         OPC_STORE:  begin dec.wr = 1'b1; end
         OPC_PATCHL: begin dec.rd = 1'b1; dec.wr = 1'b1; dec.is_patch = 1'b1; end
         OPC_PATCHR: begin dec.rd = 1'b1; dec.wr = 1'b1; dec.is_patch = 1'b1;
                           dec.patch_right = 1'b1; end
         OPC_JMPL:   begin dec.is_br = 1'b1; end
         OPC_JMPR:   begin dec.is_br = 1'b1; dec.br_right = 1'b1; end
         OPC_JGEL:   begin dec.is_br = 1'b1; dec.br_cond = 1'b1; end
         OPC_JGER:   begin dec.is_br = 1'b1; dec.br_cond = 1'b1;
                           dec.br_right = 1'b1; end
         default:    dec = '0;
      endcase
   end

endmodule

// File: rtl/accm_alu.sv
module accm_alu
   import accm_pkg::*;
#(
   parameter int W         = 40,
   parameter bit SHR_ARITH = 1'b1
) (
   input  alu_fn_e      fn,
   input  logic [W-1:0] ac,
   input  logic [W-1:0] mq,
   input  logic [W-1:0] m,
   output logic [W-1:0] res
);

   localparam int SGN = W - 1;

   logic [W-1:0] neg_m;
   logic [W-1:0] abs_m;
   logic [W-1:0] shr_v;

   assign neg_m = '0 - m;
   assign abs_m = m[SGN] ? neg_m : m;

   generate
      if (SHR_ARITH) begin : g_shr_arith
         assign shr_v = {ac[SGN], ac[SGN:1]};
      end else begin : g_shr_logic
         assign shr_v = {1'b0, ac[SGN:1]};
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_LD:      res = m;
         FN_LDNEG:   res = neg_m;
         FN_LDABS:   res = abs_m;
         FN_LDNABS:  res = '0 - abs_m;
         FN_ADD:     res = ac + m;
         FN_ADDABS:  res = ac + abs_m;
         FN_SUB:     res = ac - m;
         FN_SUBABS:  res = ac - abs_m;
         FN_SHL:     res = {ac[W-2:0], 1'b0};
         FN_SHR:     res = shr_v;
         FN_FROM_MQ: res = mq;
         default:    res = ac;
      endcase
   end

endmodule

// File: rtl/accm_patch.sv
module accm_patch #(
   parameter int W  = 40,
   parameter int FW = 12
) (
   input  logic [W-1:0]  word,
   input  logic [FW-1:0] field,
   input  logic          sel_right,
   output logic [W-1:0]  merged
);

   localparam int HALF = W / 2;
   localparam int LPOS = HALF;

   generate
      if (FW > HALF) begin : g_bad_field
         $error("accm_patch: field wider than half word");
      end
   endgenerate

   logic [W-1:0] left_v;
   logic [W-1:0] right_v;

   always_comb begin
      left_v              = word;
      left_v[LPOS +: FW]  = field;
      right_v             = word;
      right_v[0 +: FW]    = field;
   end

   assign merged = sel_right ? right_v : left_v;

endmodule

// File: rtl/accm_exec.sv
module accm_exec
   import accm_pkg::*;
#(
   parameter int WORD_W    = 40,
   parameter int ADDR_W    = 12,
   parameter bit SHR_ARITH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [OP_W-1:0]   issue_op,
   input  logic [ADDR_W-1:0] issue_addr,
   output logic              issue_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              jump_valid,
   output logic              jump_taken,
   output logic              jump_right,
   output logic [ADDR_W-1:0] jump_addr,
   output logic [WORD_W-1:0] ac_out,
   output logic [WORD_W-1:0] mq_out
);

   localparam int SGN = WORD_W - 1;

   generate
      if (ADDR_W * 2 > WORD_W) begin : g_bad_width
         $error("accm_exec: address field does not fit in a half word");
      end
   endgenerate

   exec_st_e          st_q;
   dec_t              dec_w;
   dec_t              dec_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] opnd_q;
   logic [WORD_W-1:0] wbuf_q;
   logic [WORD_W-1:0] ac_q;
   logic [WORD_W-1:0] mq_q;
   logic [WORD_W-1:0] alu_res;
   logic [WORD_W-1:0] patched;
   logic              done_q;
   logic              jv_q;
   logic              jt_q;
   logic              jr_q;
   logic [ADDR_W-1:0] ja_q;

   accm_decode u_dec (
      .op  (issue_op),
      .dec (dec_w)
   );

   accm_alu #(
      .W         (WORD_W),
      .SHR_ARITH (SHR_ARITH)
   ) u_alu (
      .fn  (dec_q.fn),
      .ac  (ac_q),
      .mq  (mq_q),
      .m   (opnd_q),
      .res (alu_res)
   );

   accm_patch #(
      .W  (WORD_W),
      .FW (ADDR_W)
   ) u_patch (
      .word      (mem_rdata),
      .field     (ac_q[ADDR_W-1:0]),
      .sel_right (dec_q.patch_right),
      .merged    (patched)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         dec_q  <= '0;
         addr_q <= '0;
         opnd_q <= '0;
         wbuf_q <= '0;
         ac_q   <= '0;
         mq_q   <= '0;
         done_q <= 1'b0;
         jv_q   <= 1'b0;
         jt_q   <= 1'b0;
         jr_q   <= 1'b0;
         ja_q   <= '0;
      end else begin
         done_q <= 1'b0;
         jv_q   <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (issue_valid) begin
                  dec_q  <= dec_w;
                  addr_q <= issue_addr;
                  if (dec_w.rd) begin
                     st_q <= ST_RD;
                  end else if (dec_w.wr) begin
                     wbuf_q <= ac_q;
                     st_q   <= ST_WR;
                  end else begin
                     st_q <= ST_FIN;
                  end
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  opnd_q <= mem_rdata;
                  if (dec_q.is_patch) begin
                     wbuf_q <= patched;
                     st_q   <= ST_WR;
                  end else begin
                     st_q <= ST_FIN;
                  end
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  st_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               if (dec_q.wr_ac) begin
                  ac_q <= alu_res;
               end
               if (dec_q.wr_mq) begin
                  mq_q <= opnd_q;
               end
               done_q <= 1'b1;
               jv_q   <= dec_q.is_br;
               jt_q   <= dec_q.is_br & (~dec_q.br_cond | ~ac_q[SGN]);
               jr_q   <= dec_q.br_right;
               ja_q   <= addr_q;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign issue_ready = (st_q == ST_IDLE);
   assign busy        = (st_q != ST_IDLE);
   assign mem_req     = (st_q == ST_RD) | (st_q == ST_WR);
   assign mem_we      = (st_q == ST_WR);
   assign mem_addr    = addr_q;
   assign mem_wdata   = wbuf_q;
   assign done        = done_q;
   assign jump_valid  = jv_q;
   assign jump_taken  = jt_q;
   assign jump_right  = jr_q;
   assign jump_addr   = ja_q;
   assign ac_out      = ac_q;
   assign mq_out      = mq_q;

endmodule

// File: rtl/accm_exec_chk.sv
module accm_exec_chk #(
   parameter int W  = 40,
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [W-1:0]  mem_wdata,
   input logic          mem_ack,
   input logic          jump_valid,
   input logic [W-1:0]  ac_out,
   input logic [W-1:0]  mq_out
);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   p_ac_only_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_out != $past(ac_out)) |-> done);

   p_mq_only_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mq_out != $past(mq_out)) |-> done);

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

   p_req_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_jump_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      jump_valid |-> done);

endmodule

bind accm_exec accm_exec_chk #(.W(WORD_W), .AW(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .jump_valid (jump_valid),
   .ac_out     (ac_out),
   .mq_out     (mq_out)
);

// File: tb/tb_accm_exec.sv
`timescale 1ns/1ps
module tb_accm_exec;

   localparam int W  = 40;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0;
   logic [7:0]    issue_op = '0;
   logic [AW-1:0] issue_addr = '0;
   logic          issue_ready;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [W-1:0]  mem_wdata;
   logic          mem_ack = 1'b0;
   logic [W-1:0]  mem_rdata = '0;
   logic          busy, done, jump_valid, jump_taken, jump_right;
   logic [AW-1:0] jump_addr;
   logic [W-1:0]  ac_out, mq_out;

   always #2.5 clk = ~clk;

   accm_exec dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
      .issue_addr(issue_addr), .issue_ready(issue_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .jump_valid(jump_valid), .jump_taken(jump_taken), .jump_right(jump_right),
      .jump_addr(jump_addr), .ac_out(ac_out), .mq_out(mq_out)
   );

   // memory model with programmable acknowledge latency
   logic [W-1:0] mem [16];
   int lat = 0;
   int wait_cnt = 0;
   int n_rd = 0;
   int n_wr = 0;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         if (wait_cnt <= 0) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               mem[mem_addr[3:0]] = mem_wdata;
               n_wr++;
            end else begin
               mem_rdata = mem[mem_addr[3:0]];
               n_rd++;
            end
            wait_cnt = lat;
         end else begin
            wait_cnt--;
         end
      end
   end

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [7:0] op);
      case (op)
         8'h01, 8'h02, 8'h03, 8'h04: return "R4";
         8'h09, 8'h0A:               return "R5";
         8'h21:                      return "R6";
         8'h05, 8'h06, 8'h07, 8'h08: return "R7";
         8'h14, 8'h15:               return "R8";
         8'h0D, 8'h0E, 8'h0F, 8'h10: return "R9";
         8'h12, 8'h13:               return "R10";
         default:                    return "R11";
      endcase
   endfunction

   logic          got_jv, got_jt, got_jr;
   logic [AW-1:0] got_ja;

   // issue one instruction and wait for completion; checks R2 timing
   task automatic run(input logic [7:0] op, input logic [AW-1:0] x);
      int cyc;
      n_rd = 0;
      n_wr = 0;
      @(negedge clk);
      issue_valid = 1'b1;
      issue_op    = op;
      issue_addr  = x;
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R2", "busy after accept", {39'b0, busy}, 40'd1);
      cyc = 0;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 completion timeout: actual 0 expected 1 (op %h)", op);
      end
      chk("R2", "busy low at done", {39'b0, busy}, 40'd0);
      got_jv = jump_valid;
      got_jt = jump_taken;
      got_jr = jump_right;
      got_ja = jump_addr;
      @(negedge clk);
      chk("R2", "done single cycle", {39'b0, done}, 40'd0);
   endtask

   function automatic logic [W-1:0] absv(input logic [W-1:0] v);
      return v[W-1] ? ('0 - v) : v;
   endfunction

   localparam logic [AW-1:0] A_AC = 12'd1;
   localparam logic [AW-1:0] A_MQ = 12'd2;
   localparam logic [AW-1:0] A_X  = 12'd5;

   logic [W-1:0] pat_ac [5];
   logic [W-1:0] pat_mq [5];
   logic [W-1:0] pat_m  [5];

   initial begin : watchdog
      #(200000 * 5);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual expired expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] eac, emq, emem, ac0, mq0, m;
      int           erd, ewr;
      logic         ejv, ejt, ejr;
      string        rq;

      pat_ac[0] = 40'h00_1234_5ABC; pat_mq[0] = 40'h7F_0000_0001; pat_m[0] = 40'hFF_FFFF_FFFF;
      pat_ac[1] = 40'hC0_0000_0F0F; pat_mq[1] = 40'h80_0000_0000; pat_m[1] = 40'h00_0000_0003;
      pat_ac[2] = 40'h80_0000_0000; pat_mq[2] = 40'h12_3456_789A; pat_m[2] = 40'h80_0000_0000;
      pat_ac[3] = 40'h7F_FFFF_FA5C; pat_mq[3] = 40'h00_0000_0000; pat_m[3] = 40'hFF_FFFF_FFFF;
      pat_ac[4] = 40'hFF_FFFF_FFFF; pat_mq[4] = 40'h55_5555_5555; pat_m[4] = 40'h00_0000_0000;
      for (int i = 0; i < 16; i++) mem[i] = '0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "ac reset", ac_out, '0);
      chk("R1", "mq reset", mq_out, '0);
      chk("R1", "busy reset", {39'b0, busy}, '0);
      chk("R1", "done reset", {39'b0, done}, '0);
      chk("R1", "mem_req reset", {39'b0, mem_req}, '0);
      chk("R1", "jump_valid reset", {39'b0, jump_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: issue while busy is ignored
      lat = 3;
      mem[6] = 40'h00_0000_0123;
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 8'h01; issue_addr = 12'd6;
      @(negedge clk);
      issue_op = 8'h14;
      while (busy) @(negedge clk);
      issue_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2", "issue during busy ignored", ac_out, 40'h00_0000_0123);
      chk("R2", "no hidden accept", {39'b0, busy}, '0);

      // near-exhaustive opcode sweep
      for (int p = 0; p < 5; p++) begin
         for (int op = 0; op < 256; op++) begin
            lat = (op + p) % 3;
            mem[A_AC] = pat_ac[p];
            mem[A_MQ] = pat_mq[p];
            run(8'h01, A_AC);
            run(8'h09, A_MQ);
            ac0 = pat_ac[p];
            mq0 = pat_mq[p];
            m   = pat_m[p];
            mem[A_X] = m;
            eac = ac0; emq = mq0; emem = m;
            erd = 0; ewr = 0;
            ejv = 1'b0; ejt = 1'b0; ejr = 1'b0;
            case (op)
               8'h01: begin eac = m; erd = 1; end
               8'h02: begin eac = '0 - m; erd = 1; end
               8'h03: begin eac = absv(m); erd = 1; end
               8'h04: begin eac = '0 - absv(m); erd = 1; end
               8'h05: begin eac = ac0 + m; erd = 1; end
               8'h07: begin eac = ac0 + absv(m); erd = 1; end
               8'h06: begin eac = ac0 - m; erd = 1; end
               8'h08: begin eac = ac0 - absv(m); erd = 1; end
               8'h09: begin emq = m; erd = 1; end
               8'h0A: eac = mq0;
               8'h21: begin emem = ac0; ewr = 1; end
               8'h14: eac = {ac0[W-2:0], 1'b0};
               8'h15: eac = {ac0[W-1], ac0[W-1:1]};
               8'h0D: begin ejv = 1; ejt = 1; ejr = 0; end
               8'h0E: begin ejv = 1; ejt = 1; ejr = 1; end
               8'h0F: begin ejv = 1; ejt = ~ac0[W-1]; ejr = 0; end
               8'h10: begin ejv = 1; ejt = ~ac0[W-1]; ejr = 1; end
               8'h12: begin emem = {m[39:32], ac0[11:0], m[19:0]}; erd = 1; ewr = 1; end
               8'h13: begin emem = {m[39:12], ac0[11:0]}; erd = 1; ewr = 1; end
               default: ;
            endcase
            run(8'(op), A_X);
            rq = req_of(8'(op));
            chk(rq, $sformatf("ac op %h", op), ac_out, eac);
            chk(rq, $sformatf("mq op %h", op), mq_out, emq);
            chk(rq, $sformatf("mem op %h", op), mem[A_X], emem);
            chk("R3", $sformatf("reads op %h", op), 40'(n_rd), 40'(erd));
            chk("R3", $sformatf("writes op %h", op), 40'(n_wr), 40'(ewr));
            chk(rq, $sformatf("jump_valid op %h", op), {39'b0, got_jv}, {39'b0, ejv});
            if (ejv) begin
               chk("R9", $sformatf("taken op %h", op), {39'b0, got_jt}, {39'b0, ejt});
               chk("R9", $sformatf("right op %h", op), {39'b0, got_jr}, {39'b0, ejr});
               chk("R9", $sformatf("target op %h", op), 40'(got_ja), 40'(A_X));
            end
         end
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule